// File: doc/BRIEF.md
# Byte Serializer with Facility and Equipment Loopback

This block is the high-speed transmit path of a line transceiver. It takes one parallel byte per byte period and sends it out as a serial stream, most significant bit first. The serial stream runs at one bit per clock of the bit-rate clock `clk`, so each byte takes `BYTE_W` bit cycles. The block raises `byteTick` for one bit cycle in each byte period. The byte on `txByte` is captured on the clock edge that ends that cycle, which marks the rising edge of the byte clock. The next byte follows the last bit of the previous one directly, with no idle bits between them.

Between the transmit and receive high-speed paths, the block also steers the serial data and clock for two loopback modes. Facility loopback sends the incoming line data and its clock straight back out on the transmit outputs, and still hands that incoming data to the receive deserializer. Equipment loopback sends the block's own serialized data, with its own clock, into the deserializer in place of the line input, and still drives that data onto the transmit line. The two modes are not meant to be active together. If both are requested, facility loopback wins and an error flag is raised.

The receive line input is taken to be synchronous to `clk`. The clock steering is a plain selection between clocks, and a clock-switching cell is expected to take its place at implementation.

Top module: `byte_ser_loop`

## Requirements
- R1: `byteTick` is high for exactly one bit cycle in every `BYTE_W` cycles. The value on `txByte` at the rising `clk` edge that ends a `byteTick` cycle is the byte that is transmitted next.
- R2: During the `j`-th bit cycle after the capture edge (j = 0 .. BYTE_W-1), the transmit serial bit is bit index `BYTE_W-1-j` of the captured byte. Bit `BYTE_W-1` is the most significant bit and is sent first.
- R3: Bytes follow each other with no gap bits. The cycle that carries the last bit of a byte is also the next `byteTick` cycle.
- R4: Out of synchronous reset (`rst` high), the transmit serial bit is 0 and `byteTick` is 0. The first `byteTick` is seen after `BYTE_W-1` clock edges.
- R5: While `facLoop` is 1, `txSerOut` equals `rxSerIn` and `txClkOut` equals `rxClkIn`.
- R6: While `facLoop` is 1, `desSerOut` equals `rxSerIn` and `desClkOut` equals `rxClkIn`.
- R7: While `equLoop` is 1 and `facLoop` is 0, `desSerOut` carries the transmit serial bit and `desClkOut` equals `clk`.
- R8: While `equLoop` is 1 and `facLoop` is 0, `txSerOut` still carries the transmit serial bit and `txClkOut` equals `clk`.
- R9: `loopErr` is 1 exactly when `facLoop` and `equLoop` are both 1. In that case the outputs follow R5 and R6, because facility loopback takes priority.
- R10: With both loopback controls at 0, `txSerOut` carries the transmit serial bit, `txClkOut` equals `clk`, and `desSerOut`/`desClkOut` equal `rxSerIn`/`rxClkIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| txByte | input | BYTE_W | Parallel transmit byte |
| byteTick | output | 1 | High in the bit cycle whose ending edge captures `txByte` |
| txSerOut | output | 1 | Serial transmit line data |
| txClkOut | output | 1 | Transmit line clock |
| rxSerIn | input | 1 | Serial receive line data |
| rxClkIn | input | 1 | Receive line clock |
| desSerOut | output | 1 | Serial data fed to the receive deserializer |
| desClkOut | output | 1 | Clock fed to the receive deserializer |
| facLoop | input | 1 | Facility loopback request |
| equLoop | input | 1 | Equipment loopback request |
| loopErr | output | 1 | Both loopbacks requested at once |

## Verification
The bench builds the block with the default `BYTE_W` of 8. This is small enough to send all 256 byte values back to back under each of the four combinations of the loopback controls. Every bit position of every code is therefore compared against the arithmetic expectation in every mode, and each mode change happens at a byte boundary while the stream keeps running. The receive line pattern changes bit by bit, and `rxClkIn` is held opposite to `clk` at the sampling point, so any steering that picks the wrong data or clock source shows up at the ports.

// File: rtl/byte_ser_pkg.sv
package byte_ser_pkg;
  typedef struct packed {
    logic load;    // take a new byte this edge
    logic shift;   // advance the shift register this edge
    logic facSel;  // steer line receive to transmit outputs
    logic equSel;  // steer transmit serial into deserializer
  } serStrobes_t;
endpackage

// File: rtl/byte_ser_ctrl.sv
module byte_ser_ctrl
  import byte_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        facLoop,
  input  logic        equLoop,
  output serStrobes_t strobes,
  output logic        byteTick,
  output logic        loopErr
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic atLast;

  assign atLast = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (atLast) begin
      bitCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.load   = atLast;
    strobes.shift  = !atLast;
    strobes.facSel = facLoop;
    strobes.equSel = equLoop && !facLoop;
  end

  assign byteTick = atLast;
  assign loopErr  = facLoop && equLoop;
endmodule

// File: rtl/byte_ser_dp.sv
module byte_ser_dp
  import byte_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  serStrobes_t       strobes,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              rxSerIn,
  input  logic              rxClkIn,
  output logic              txSerOut,
  output logic              txClkOut,
  output logic              desSerOut,
  output logic              desClkOut
);
  logic [BYTE_W-1:0] shiftReg;
  logic txBit;

  generate
    if (BYTE_W > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          shiftReg <= '0;
        end else if (strobes.load) begin
          shiftReg <= txByte;
        end else if (strobes.shift) begin
          shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          shiftReg <= '0;
        end else if (strobes.load) begin
          shiftReg <= txByte;
        end
      end
    end
  endgenerate

  assign txBit = shiftReg[BYTE_W-1];

  always_comb begin
    if (strobes.facSel) begin
      txSerOut = rxSerIn;
      txClkOut = rxClkIn;
    end else begin
      txSerOut = txBit;
      txClkOut = clk;
    end
    if (strobes.equSel) begin
      desSerOut = txBit;
      desClkOut = clk;
    end else begin
      desSerOut = rxSerIn;
      desClkOut = rxClkIn;
    end
  end
endmodule

// File: rtl/byte_ser_loop.sv
module byte_ser_loop
  import byte_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] txByte,
  output logic              byteTick,
  output logic              txSerOut,
  output logic              txClkOut,
  input  logic              rxSerIn,
  input  logic              rxClkIn,
  output logic              desSerOut,
  output logic              desClkOut,
  input  logic              facLoop,
  input  logic              equLoop,
  output logic              loopErr
);
  serStrobes_t strobes;

  byte_ser_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst), .facLoop(facLoop), .equLoop(equLoop),
    .strobes(strobes), .byteTick(byteTick), .loopErr(loopErr)
  );

  byte_ser_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .txByte(txByte),
    .rxSerIn(rxSerIn), .rxClkIn(rxClkIn),
    .txSerOut(txSerOut), .txClkOut(txClkOut),
    .desSerOut(desSerOut), .desClkOut(desClkOut)
  );
endmodule

// File: rtl/byte_ser_loop_chk.sv
module byte_ser_loop_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] txByte,
  input logic              byteTick,
  input logic              txSerOut,
  input logic              rxSerIn,
  input logic              desSerOut,
  input logic              facLoop,
  input logic              equLoop,
  input logic              loopErr
);
  logic [15:0] sinceTick;
  logic seenTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceTick <= '0;
      seenTick  <= 1'b0;
    end else if (byteTick) begin
      sinceTick <= '0;
      seenTick  <= 1'b1;
    end else begin
      sinceTick <= sinceTick + 1'b1;
    end
  end

  // R1 R3: ticks repeat every BYTE_W cycles
  assert_tick_period_R3: assert property (@(posedge clk) disable iff (rst)
    (byteTick && seenTick) |-> (32'(sinceTick) == BYTE_W - 1));

  // R2: first bit out after capture is the byte's MSB
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
    (byteTick && !facLoop) ##1 !facLoop |-> txSerOut == $past(txByte[BYTE_W-1]));

  // R5: facility loopback mirrors line data to transmit
  assert_fac_tx_R5: assert property (@(posedge clk) disable iff (rst)
    facLoop |-> txSerOut == rxSerIn);

  // R7: equipment loopback feeds transmit serial into deserializer
  assert_equ_des_R7: assert property (@(posedge clk) disable iff (rst)
    (equLoop && !facLoop) |-> desSerOut == txSerOut);

  // R9: error flag follows the conflicting request
  assert_conflict_flag_R9: assert property (@(posedge clk) disable iff (rst)
    loopErr == (facLoop && equLoop));

  // R10: without equipment loopback the deserializer sees the line
  assert_des_line_R10: assert property (@(posedge clk) disable iff (rst)
    (!equLoop || facLoop) |-> desSerOut == rxSerIn);
endmodule

bind byte_ser_loop byte_ser_loop_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .txByte(txByte), .byteTick(byteTick),
  .txSerOut(txSerOut), .rxSerIn(rxSerIn), .desSerOut(desSerOut),
  .facLoop(facLoop), .equLoop(equLoop), .loopErr(loopErr)
);

// File: tb/byte_ser_loop_tb.sv
module byte_ser_loop_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] txByte = '0;
  logic byteTick, txSerOut, txClkOut, desSerOut, desClkOut, loopErr;
  logic rxSerIn = 1'b0;
  logic rxClkIn = 1'b1;
  logic facLoop = 1'b0;
  logic equLoop = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_ser_loop #(.BYTE_W(W)) u_dut (
    .clk(clk), .rst(rst), .txByte(txByte), .byteTick(byteTick),
    .txSerOut(txSerOut), .txClkOut(txClkOut),
    .rxSerIn(rxSerIn), .rxClkIn(rxClkIn),
    .desSerOut(desSerOut), .desClkOut(desClkOut),
    .facLoop(facLoop), .equLoop(equLoop), .loopErr(loopErr)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int firstWait;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R4: reset state
    check("R4 txSerOut", txSerOut, 1'b0);
    check("R4 byteTick", byteTick, 1'b0);
    check("R9 loopErr idle", loopErr, 1'b0);
    firstWait = 0;
    while (!byteTick) begin
      @(negedge clk);
      #1;
      firstWait++;
      if (firstWait > 2 * W) break;
    end
    // R4: first tick after W-1 edges
    check("R4 first tick position", firstWait == W - 1, 1'b1);

    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < (1 << W); v++) begin
        logic [W-1:0] b;
        b = W'(v);
        // at a negedge in a tick cycle: drive byte and mode
        txByte  = b;
        facLoop = m[0];
        equLoop = m[1];
        for (int j = 0; j < W; j++) begin
          logic txBit, lineBit;
          @(negedge clk);
          lineBit = ^(W'(v * 7 + j * 3 + m));
          rxSerIn = lineBit;
          txByte  = ~b;  // must not disturb the byte being sent (R1)
          #1;
          txBit = b[W-1-j];
          // R3: tick only on the last bit of each byte
          check("R3 tick spacing", byteTick, (j == W - 1) ? 1'b1 : 1'b0);
          check("R9 loopErr", loopErr, (m == 3) ? 1'b1 : 1'b0);
          if (m[0]) begin
            // R5 R6 R9: facility loopback, priority over equipment
            check("R5 tx data", txSerOut, lineBit);
            check("R5 tx clock", txClkOut, rxClkIn);
            check("R6 des data", desSerOut, lineBit);
            check("R6 des clock", desClkOut, rxClkIn);
          end else if (m[1]) begin
            // R7 R8 R2: equipment loopback
            check("R8 R2 tx data", txSerOut, txBit);
            check("R8 tx clock", txClkOut, clk);
            check("R7 des data", desSerOut, txBit);
            check("R7 des clock", desClkOut, clk);
          end else begin
            // R10 R2 R1: normal operation
            check("R10 R2 R1 tx data", txSerOut, txBit);
            check("R10 tx clock", txClkOut, clk);
            check("R10 des data", desSerOut, lineBit);
            check("R10 des clock", desClkOut, rxClkIn);
          end
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule